// File: doc/BRIEF.md
# Frame Clock Sequence Monitor

This block watches a frame clock (the left/right word clock of a serial audio stream) and checks that each of its periods spans a fixed whole number of master clock cycles. A rate-select input sets that number to 384 or 256. The frame clock is brought into the master clock domain through a two-stage synchronizer. The block measures the distance between successive rising edges and judges each period against a window around the nominal length. The window is not symmetric: it allows more extra cycles than missing ones.

From the accepted frame edges the block runs a sequence counter that downstream arithmetic uses for its timing. The counter starts on the first frame edge after reset. It then runs freely, modulo the nominal length, and strobes at each return to zero. After four accepted periods in a row the block raises a locked flag. A period outside the window does three things: it drops the lock, pulses an error flag, and stops the counter until the next frame edge realigns it. A separate through-mode select chooses what drives the serial outputs. It routes either the incoming frame clock, bit clock and data, or the conversion path's versions of them.

Top module: `frame_seq_monitor`

## Requirements
- R1: While `rst_n` is low at a master clock edge, that edge clears `seq_cnt`, `frame_start`, `locked` and `seq_err` to 0. They remain 0 until a frame clock rising edge has been seen after reset.
- R2: A rising edge of `frm_clk_in` takes effect through a two-stage synchronizer. If the input is first sampled high at master edge k, the sequence restart is visible after edge k+2.
- R3: While the sequence runs, `seq_cnt` advances by one per master cycle. It wraps to 0 after value N-1, where N is 384 when `rate_sel` is 1 and 256 when it is 0. `frame_start` is high for exactly the one cycle in which `seq_cnt` is 0.
- R4: With `rate_sel` = 1, a measured frame period P (in master cycles, from one synchronized rising edge to the next) is accepted when 378 <= P <= 392.
- R5: With `rate_sel` = 0, a period is accepted when 253 <= P <= 260.
- R6: `locked` goes to 1 in the cycle after the fourth consecutive accepted period is measured. It stays 1 while periods remain accepted.
- R7: A rejected period clears `locked` and pulses `seq_err` for exactly one cycle. A period that is too short is rejected at its closing edge. A period that is too long is rejected as soon as the maximum length passes without an edge, including when the frame clock stops.
- R8: After a rejection, `seq_cnt` holds at 0 and `frame_start` stays low until the next synchronized frame rising edge. That edge restarts the count at 0 with a strobe.
- R9: When `thru_n` is 0, `frm_clk_out`, `bit_clk_out` and `dat_out` follow `frm_clk_in`, `bit_clk_in` and `dat_in`. When `thru_n` is 1, they follow `cnv_frm_clk`, `cnv_bit_clk` and `cnv_dat`.
- R10: The first frame rising edge after reset, or after a too-long rejection, is not measured. It starts the sequence and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 1 | 1: 384 master cycles per frame, 0: 256 |
| thru_n | input | 1 | 0: pass input serial signals to outputs, 1: pass conversion path |
| frm_clk_in | input | 1 | Asynchronous incoming frame clock |
| bit_clk_in | input | 1 | Incoming bit clock |
| dat_in | input | 1 | Incoming serial data |
| cnv_frm_clk | input | 1 | Frame clock from the conversion path |
| cnv_bit_clk | input | 1 | Bit clock from the conversion path |
| cnv_dat | input | 1 | Serial data from the conversion path |
| frm_clk_out | output | 1 | Selected frame clock |
| bit_clk_out | output | 1 | Selected bit clock |
| dat_out | output | 1 | Selected serial data |
| seq_cnt | output | 9 | Sequence counter value |
| frame_start | output | 1 | One-cycle strobe when the counter is at 0 |
| locked | output | 1 | Four or more consecutive accepted periods |
| seq_err | output | 1 | One-cycle pulse on a rejected period |

## Verification
The bench builds the block with its default parameters: nominal lengths 384 and 256, tolerances +8/-6 and +4/-3, and a lock after four frames. With these values it can drive periods exactly on each window edge and one cycle beyond it, in both rates. It also covers a stopped frame clock, a reset in the middle of a run, and a change of rate. The four-frame lock and loss of lock show up within a few thousand master cycles per case.

// File: rtl/fsm_pkg.sv
// Package: shared verdict type for the frame sequence monitor.
// Assumes: one verdict per master clock cycle, at most one frame edge per cycle.
package fsm_pkg;

    // Outcome of the current master cycle as judged by the period checker
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,   // no frame edge, window still open
        EV_FIRST = 3'd1,   // edge with no reference edge before it
        EV_GOOD  = 3'd2,   // edge closing a period inside the window
        EV_SHORT = 3'd3,   // edge closing a period below the window
        EV_LONG  = 3'd4    // window closed without an edge
    } frame_ev_e;

    // True for the two rejection verdicts
    function automatic logic ev_is_fault(frame_ev_e ev);
        return (ev == EV_SHORT) || (ev == EV_LONG);
    endfunction

    // True for a frame edge that may (re)start the sequence
    function automatic logic ev_is_accept(frame_ev_e ev);
        return (ev == EV_FIRST) || (ev == EV_GOOD);
    endfunction

endpackage

// File: rtl/fsm_edge_sync.sv
// Module: fsm_edge_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops and flags its rising edges, one cycle wide.
// Assumes: the input stays high and low for at least two clock cycles each.
module fsm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] pipe;

    // Shift chain: STAGES synchronizer flops plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/fsm_period_chk.sv
// Module: fsm_period_chk
// Counts master cycles between synchronized frame edges and classifies each
// cycle: first edge, accepted period, short period, or overlong (timeout).
// Assumes: min_len <= max_len and both fit in PER_W bits.
module fsm_period_chk import fsm_pkg::*; #(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [PER_W-1:0] min_len,
    input  logic [PER_W-1:0] max_len,
    output frame_ev_e        ev
);

    logic             have_ref;
    logic [PER_W-1:0] per_cnt;

    // Verdict for this cycle from the distance to the last reference edge
    always_comb begin
        ev = EV_NONE;
        if (rise) begin
            if (!have_ref)              ev = EV_FIRST;
            else if (per_cnt < min_len) ev = EV_SHORT;
            else                        ev = EV_GOOD;
        end else if (have_ref && (per_cnt >= max_len)) begin
            ev = EV_LONG;
        end
    end

    // Reference tracking and period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_ref <= 1'b0;
            per_cnt  <= '0;
        end else if (rise) begin
            have_ref <= 1'b1;
            per_cnt  <= {{(PER_W-1){1'b0}}, 1'b1};
        end else if (ev == EV_LONG) begin
            have_ref <= 1'b0;
            per_cnt  <= '0;
        end else if (have_ref) begin
            per_cnt  <= per_cnt + 1'b1;
        end
    end

    AST_PERIOD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (have_ref && $stable(max_len)) |-> (per_cnt <= max_len)); // R7

    AST_TIMEOUT_DROPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_LONG) |=> !have_ref); // R10

endmodule

// File: rtl/fsm_lock_track.sv
// Module: fsm_lock_track
// Counts consecutive accepted periods to raise the lock flag, and turns any
// rejection into a one-cycle error pulse that also drops the lock.
// Assumes: LOCK_FRAMES >= 1.
module fsm_lock_track import fsm_pkg::*; #(
    parameter int LOCK_FRAMES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  frame_ev_e ev,
    output logic      locked,
    output logic      seq_err
);

    localparam int GW = $clog2(LOCK_FRAMES + 1);

    logic [GW-1:0] good_cnt;
    logic          fault;

    assign fault = ev_is_fault(ev);

    // Consecutive accepted-period count and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (fault) begin
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (ev == EV_GOOD) begin
            if (good_cnt < GW'(LOCK_FRAMES))      good_cnt <= good_cnt + 1'b1;
            if (good_cnt == GW'(LOCK_FRAMES - 1)) locked   <= 1'b1;
        end
    end

    // Registered error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) seq_err <= 1'b0;
        else        seq_err <= fault;
    end

    AST_ERR_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> !locked); // R7
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_err); // R7
    AST_LOCK_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ev == EV_GOOD)); // R6

endmodule

// File: rtl/fsm_seq_gen.sv
// Module: fsm_seq_gen
// Sequence counter for downstream timing: starts on an accepted frame edge,
// free-runs modulo the nominal length, halts at zero on any rejection.
// Assumes: last_idx >= 1.
module fsm_seq_gen import fsm_pkg::*; #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  frame_ev_e        ev,
    input  logic [CNT_W-1:0] last_idx,
    output logic [CNT_W-1:0] seq_cnt,
    output logic             frame_start,
    output logic             running
);

    // Counter, run flag and zero strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running     <= 1'b0;
            seq_cnt     <= '0;
            frame_start <= 1'b0;
        end else if (ev_is_fault(ev)) begin
            running     <= 1'b0;
            seq_cnt     <= '0;
            frame_start <= 1'b0;
        end else if (running) begin
            if (seq_cnt >= last_idx) begin
                seq_cnt     <= '0;
                frame_start <= 1'b1;
            end else begin
                seq_cnt     <= seq_cnt + 1'b1;
                frame_start <= 1'b0;
            end
        end else if (ev_is_accept(ev)) begin
            running     <= 1'b1;
            seq_cnt     <= '0;
            frame_start <= 1'b1;
        end else begin
            frame_start <= 1'b0;
        end
    end

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (seq_cnt == '0) && !frame_start); // R8
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R3
    AST_RESTART_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && ev_is_accept(ev)) |=> frame_start); // R8

endmodule

// File: rtl/frame_seq_monitor.sv
// Module: frame_seq_monitor (top)
// Checks the frame clock period against a rate-dependent asymmetric window,
// drives the sequence counter, lock and error flags, and selects the source
// of the serial outputs.
// Assumes: rate_sel and thru_n are quasi-static; frm_clk_in is asynchronous.
module frame_seq_monitor import fsm_pkg::*; #(
    parameter int NOM_WIDE     = 384,
    parameter int NOM_NARROW   = 256,
    parameter int WIDE_PLUS    = 8,
    parameter int WIDE_MINUS   = 6,
    parameter int NARROW_PLUS  = 4,
    parameter int NARROW_MINUS = 3,
    parameter int LOCK_FRAMES  = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                   clk_mst,
    input  logic                   rst_n,
    input  logic                   rate_sel,
    input  logic                   thru_n,
    input  logic                   frm_clk_in,
    input  logic                   bit_clk_in,
    input  logic                   dat_in,
    input  logic                   cnv_frm_clk,
    input  logic                   cnv_bit_clk,
    input  logic                   cnv_dat,
    output logic                   frm_clk_out,
    output logic                   bit_clk_out,
    output logic                   dat_out,
    output logic [8:0]             seq_cnt,
    output logic                   frame_start,
    output logic                   locked,
    output logic                   seq_err
);

    localparam int NOM_MAX  = (NOM_WIDE > NOM_NARROW) ? NOM_WIDE : NOM_NARROW;
    localparam int LEN_WIDE = NOM_WIDE + WIDE_PLUS;
    localparam int LEN_NARR = NOM_NARROW + NARROW_PLUS;
    localparam int LEN_MAX  = (LEN_WIDE > LEN_NARR) ? LEN_WIDE : LEN_NARR;
    localparam int CNT_W    = $clog2(NOM_MAX);
    localparam int PER_W    = $clog2(LEN_MAX + 1);

    localparam logic [PER_W-1:0] WIDE_MIN = PER_W'(NOM_WIDE - WIDE_MINUS);
    localparam logic [PER_W-1:0] WIDE_MAX = PER_W'(LEN_WIDE);
    localparam logic [PER_W-1:0] NARR_MIN = PER_W'(NOM_NARROW - NARROW_MINUS);
    localparam logic [PER_W-1:0] NARR_MAX = PER_W'(LEN_NARR);
    localparam logic [CNT_W-1:0] WIDE_LAST = CNT_W'(NOM_WIDE - 1);
    localparam logic [CNT_W-1:0] NARR_LAST = CNT_W'(NOM_NARROW - 1);

    logic             rise_w;
    logic             run_w;
    frame_ev_e        ev_w;
    logic [PER_W-1:0] min_len;
    logic [PER_W-1:0] max_len;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] cnt_w;

    // Window limits and wrap point for the selected rate
    always_comb begin
        min_len  = rate_sel ? WIDE_MIN  : NARR_MIN;
        max_len  = rate_sel ? WIDE_MAX  : NARR_MAX;
        last_idx = rate_sel ? WIDE_LAST : NARR_LAST;
    end

    fsm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk_mst),
        .rst_n    (rst_n),
        .async_in (frm_clk_in),
        .rise     (rise_w)
    );

    fsm_period_chk #(.PER_W(PER_W)) per_i (
        .clk     (clk_mst),
        .rst_n   (rst_n),
        .rise    (rise_w),
        .min_len (min_len),
        .max_len (max_len),
        .ev      (ev_w)
    );

    fsm_lock_track #(.LOCK_FRAMES(LOCK_FRAMES)) lock_i (
        .clk     (clk_mst),
        .rst_n   (rst_n),
        .ev      (ev_w),
        .locked  (locked),
        .seq_err (seq_err)
    );

    fsm_seq_gen #(.CNT_W(CNT_W)) seq_i (
        .clk         (clk_mst),
        .rst_n       (rst_n),
        .ev          (ev_w),
        .last_idx    (last_idx),
        .seq_cnt     (cnt_w),
        .frame_start (frame_start),
        .running     (run_w)
    );

    // Fit the internal counter onto the fixed-width output port
    generate
        if (CNT_W >= 9) begin : g_cnt_trim
            assign seq_cnt = cnt_w[8:0];
        end else begin : g_cnt_pad
            assign seq_cnt = {{(9-CNT_W){1'b0}}, cnt_w};
        end
    endgenerate

    // Serial output source select
    always_comb begin
        if (!thru_n) begin
            frm_clk_out = frm_clk_in;
            bit_clk_out = bit_clk_in;
            dat_out     = dat_in;
        end else begin
            frm_clk_out = cnv_frm_clk;
            bit_clk_out = cnv_bit_clk;
            dat_out     = cnv_dat;
        end
    end

    AST_LOCK_NEEDS_RUN: assert property (@(posedge clk_mst) disable iff (!rst_n)
        locked |-> run_w); // R6
    AST_ERR_STOPS_SEQ: assert property (@(posedge clk_mst) disable iff (!rst_n)
        seq_err |-> (seq_cnt == '0) && !frame_start); // R8

endmodule

// File: tb/frame_seq_monitor_tb_top.sv
module frame_seq_monitor_tb_top;

    logic clk_mst = 1'b0;
    always #4 clk_mst = ~clk_mst;

    logic       rst_n = 1'b0, rate_sel = 1'b1, thru_n = 1'b1;
    logic       frm_clk_in = 1'b0, bit_clk_in = 1'b0, dat_in = 1'b0;
    logic       cnv_frm_clk = 1'b0, cnv_bit_clk = 1'b0, cnv_dat = 1'b0;
    logic       frm_clk_out, bit_clk_out, dat_out;
    logic [8:0] seq_cnt;
    logic       frame_start, locked, seq_err;

    frame_seq_monitor dut_i (
        .clk_mst(clk_mst), .rst_n(rst_n), .rate_sel(rate_sel), .thru_n(thru_n),
        .frm_clk_in(frm_clk_in), .bit_clk_in(bit_clk_in), .dat_in(dat_in),
        .cnv_frm_clk(cnv_frm_clk), .cnv_bit_clk(cnv_bit_clk), .cnv_dat(cnv_dat),
        .frm_clk_out(frm_clk_out), .bit_clk_out(bit_clk_out), .dat_out(dat_out),
        .seq_cnt(seq_cnt), .frame_start(frame_start), .locked(locked),
        .seq_err(seq_err)
    );

    int    checks = 0;
    int    errors = 0;
    int    tick_no = 0;
    string phase = "R1";

    // Behavioural reference state
    bit m_sync[$] = '{0, 0, 0};
    int m_per = 0, m_seq = 0, m_good = 0;
    bit m_ref = 0, m_run = 0, m_fs = 0, m_lock = 0, m_err = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: act=%0d exp=%0d (tick %0d)", phase, tag, act, exp, tick_no);
        end
    endtask

    // Advance the reference by one master edge using the inputs seen at it
    task automatic step_model();
        int  nom, lo, hi;
        bit  rise, fault, good;
        nom = rate_sel ? 384 : 256;
        lo  = rate_sel ? 6 : 3;
        hi  = rate_sel ? 8 : 4;
        if (!rst_n) begin
            m_sync = '{0, 0, 0};
            m_per = 0; m_seq = 0; m_good = 0;
            m_ref = 0; m_run = 0; m_fs = 0; m_lock = 0; m_err = 0;
            return;
        end
        rise = m_sync[1] && !m_sync[2];
        m_sync.push_front(frm_clk_in);
        void'(m_sync.pop_back());
        fault = 0; good = 0;
        if (rise) begin
            if (m_ref && m_per < nom - lo) fault = 1;
            else if (m_ref) good = 1;
            m_per = 1; m_ref = 1;
        end else if (m_ref) begin
            if (m_per >= nom + hi) begin fault = 1; m_ref = 0; m_per = 0; end
            else m_per++;
        end
        if (fault) begin
            m_run = 0; m_seq = 0; m_fs = 0;
        end else if (m_run) begin
            m_seq = (m_seq >= nom - 1) ? 0 : m_seq + 1;
            m_fs  = (m_seq == 0);
        end else if (rise) begin
            m_run = 1; m_seq = 0; m_fs = 1;
        end else begin
            m_fs = 0;
        end
        if (fault) begin
            m_good = 0; m_lock = 0;
        end else if (good) begin
            if (m_good < 4) m_good++;
            if (m_good == 4) m_lock = 1;
        end
        m_err = fault;
    endtask

    // One master cycle: model, compare, then drive the next inputs
    task automatic tick(bit f);
        @(negedge clk_mst);
        tick_no++;
        step_model();
        chk("R3 seq_cnt", int'(seq_cnt), m_seq);
        chk("R3 frame_start", int'(frame_start), int'(m_fs));
        chk("R6 locked", int'(locked), int'(m_lock));
        chk("R7 seq_err", int'(seq_err), int'(m_err));
        frm_clk_in  = f;
        bit_clk_in  = tick_no[0];
        dat_in      = tick_no[2];
        cnv_frm_clk = ~tick_no[1];
        cnv_bit_clk = ~tick_no[0];
        cnv_dat     = tick_no[3];
        #1;
        chk("R9 frm_clk_out", int'(frm_clk_out), int'(thru_n ? cnv_frm_clk : frm_clk_in));
        chk("R9 bit_clk_out", int'(bit_clk_out), int'(thru_n ? cnv_bit_clk : bit_clk_in));
        chk("R9 dat_out", int'(dat_out), int'(thru_n ? cnv_dat : dat_in));
    endtask

    task automatic frames(int n, int p);
        for (int i = 0; i < n; i++)
            for (int c = 0; c < p; c++) tick(c < p / 2);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    initial begin
        // R1: reset holds everything at zero even with a toggling frame clock
        phase = "R1";
        rst_n = 1'b0;
        frames(2, 40);
        rst_n = 1'b1;
        idle(6);
        // R2: first edge after reset, restart through two sync stages
        phase = "R2 R10";
        frames(1, 384);
        phase = "R3 R6";
        frames(6, 384);
        phase = "R4";
        frames(1, 392);
        frames(1, 378);
        frames(2, 384);
        phase = "R7 long";
        frames(1, 393);
        phase = "R8 R10";
        frames(5, 384);
        phase = "R7 short";
        frames(1, 377);
        phase = "R8";
        frames(5, 384);
        // R1: reset in the middle of a run, switch to the narrow rate
        phase = "R1 mid";
        rst_n = 1'b0;
        rate_sel = 1'b0;
        frames(1, 100);
        rst_n = 1'b1;
        idle(3);
        phase = "R5 R9";
        thru_n = 1'b0;
        frames(6, 256);
        frames(1, 260);
        frames(1, 253);
        frames(2, 256);
        frames(1, 261);
        frames(5, 256);
        thru_n = 1'b1;
        frames(1, 252);
        frames(5, 256);
        // R7: frame clock stops, timeout fires without any edge
        phase = "R7 stop";
        idle(400);
        phase = "R10";
        frames(6, 256);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule